// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block steps through the column addresses of a synchronous DRAM burst, producing one address on each clock. A column command loads a start column, a burst length code, a wrap order and a read latency code. Starting on the next clock, the block walks the aligned block of columns that holds the start column, in either linear-wrap order or XOR order. While it does so it raises a busy flag. A read-valid flag follows that busy flag, delayed by the latched read latency, so the data path knows when returning data lines up with each address.

A new column command may arrive on any clock. When it does, the running burst stops and the new one begins on the next clock. A separate terminate pulse ends a burst early. The memory array and the data path are not part of this block.

Top module: `burst_col_seq`

## Requirements
- R1: Burst length code `bl_sel_i` 0, 1, 2 and 3 selects 1, 2, 4 and 8 addresses. After a command, `busy_o` is high from the next clock for exactly that many clocks, unless a later command or a terminate pulse cuts the burst short.
- R2: When `wrap_ilv_i` = 0 (sequential), the n-th address (n counted from 0) keeps every bit above the low log2(BL) bits of the start column. Its low log2(BL) bits equal the start column's low bits plus n, modulo BL.
- R3: When `wrap_ilv_i` = 1 (interleaved), the n-th address equals the start column with its low log2(BL) bits XORed with n.
- R4: With burst length 1, the burst gives exactly one address, which is the start column itself, in either wrap order.
- R5: A command is taken on any rising edge, including during a burst. It ends the running burst, and the new burst's first address appears on the next clock with the new parameters.
- R6: A pulse on `stop_i` without a command makes `busy_o` low from the next clock. A command on the same edge wins over `stop_i`.
- R7: `rd_vld_o` equals `busy_o` delayed by L clocks. L is taken from `cl_sel_i` at the command: code 1, 2 or 3 gives that many clocks, and code 0 behaves as 1.
- R8: While reset is active and after it is released, `busy_o` and `rd_vld_o` are low until a command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Column command strobe |
| col_i | input | 9 | Start column |
| bl_sel_i | input | 2 | Burst length code |
| wrap_ilv_i | input | 1 | 0 sequential, 1 interleaved |
| cl_sel_i | input | 2 | Read latency code |
| stop_i | input | 1 | Burst terminate pulse |
| col_o | output | 9 | Current column address |
| busy_o | output | 1 | Burst in progress |
| rd_vld_o | output | 1 | Busy delayed by read latency |

## Verification
The hardest case to reach is a command that lands while an earlier burst is still running and the read-valid pipeline still holds that burst's delayed busy bits. When both bursts also use different latencies, the pipeline tap moves while old bits are still in flight. The random stimulus issues commands and terminate pulses often during active bursts, with all lengths, wrap orders and latency codes, including code 0. Directed bursts cover every length and wrap order from a start column with nonzero low bits, so that the wrap is visible.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {WRAP_SEQ = 1'b0, WRAP_ILV = 1'b1} wrap_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int CNT_W = 3,
  parameter int BL_W  = 2,
  parameter int CL_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [BL_W-1:0]  bl_sel_i,
  input  logic             wrap_ilv_i,
  input  logic [CL_W-1:0]  cl_sel_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mask_o,
  output logic [COL_W-1:0] start_o,
  output wrap_e            wrap_o,
  output logic [CL_W-1:0]  cl_o
);
  logic [CNT_W-1:0] mask_d;
  logic [CL_W-1:0]  cl_d;

  assign mask_d = CNT_W'((1 << bl_sel_i) - 1);
  assign cl_d   = (cl_sel_i == '0) ? CL_W'(1) : cl_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      mask_o   <= '0;
      start_o  <= '0;
      wrap_o   <= WRAP_SEQ;
      cl_o     <= CL_W'(1);
    end else if (cmd_i) begin
      active_o <= 1'b1;
      cnt_o    <= '0;
      mask_o   <= mask_d;
      start_o  <= col_i;
      wrap_o   <= wrap_e'(wrap_ilv_i);
      cl_o     <= cl_d;
    end else if (stop_i) begin
      active_o <= 1'b0;
    end else if (active_o) begin
      if (cnt_o == mask_o) active_o <= 1'b0;
      else                 cnt_o    <= cnt_o + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (cnt_o <= mask_o)); // R1
  AST_BURST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && cnt_o == mask_o && !cmd_i) |=> !active_o); // R4
  AST_CMD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> (active_o && cnt_o == '0)); // R5
  AST_STOP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !cmd_i) |=> !active_o); // R6
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [COL_W-1:0] start_i,
  input  wrap_e            wrap_i,
  output logic [COL_W-1:0] col_o
);
  logic [CNT_W-1:0] base_lo, seq_lo, ilv_lo, step_lo, out_lo;

  assign base_lo = start_i[CNT_W-1:0];
  assign seq_lo  = base_lo + cnt_i;
  assign ilv_lo  = base_lo ^ cnt_i;
  assign step_lo = (wrap_i == WRAP_ILV) ? ilv_lo : seq_lo;

  for (genvar b = 0; b < CNT_W; b++) begin : g_lo
    assign out_lo[b] = mask_i[b] ? step_lo[b] : base_lo[b];
  end

  assign col_o = {start_i[COL_W-1:CNT_W], out_lo};

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && wrap_i == WRAP_SEQ && cnt_i != '0 && $past(active_i))
    |-> ((col_o[CNT_W-1:0] & mask_i) ==
         ((CNT_W'($past(col_o[CNT_W-1:0]) + 1'b1)) & mask_i))); // R2
  AST_HI_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i != '0 && $past(active_i))
    |-> (col_o[COL_W-1:CNT_W] == $past(col_o[COL_W-1:CNT_W]))); // R2
endmodule

// File: rtl/burst_lat_pipe.sv
module burst_lat_pipe #(
  parameter int CL_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [CL_W-1:0] cl_i,
  output logic            rd_vld_o
);
  localparam int SR_N = 1 << CL_W;
  logic [SR_N-1:0] sr_q;
  logic [CL_W-1:0] tap;

  for (genvar s = 0; s < SR_N; s++) begin : g_sr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[s] <= 1'b0;
      else if (s == 0) sr_q[s] <= active_i;
      else sr_q[s] <= sr_q[(s == 0) ? 0 : s-1];
    end
  end

  assign tap      = cl_i - CL_W'(1);
  assign rd_vld_o = sr_q[tap];

  AST_RDV_CL1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_i == CL_W'(1) && $past(cl_i) == CL_W'(1)) |-> (rd_vld_o == $past(active_i))); // R7
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BL_MAX = 8,
  parameter int CL_MAX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       bl_sel_i,
  input  logic             wrap_ilv_i,
  input  logic [1:0]       cl_sel_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o,
  output logic             rd_vld_o
);
  localparam int CNT_W = $clog2(BL_MAX);
  localparam int CL_W  = $clog2(CL_MAX + 1);

  logic             active;
  logic [CNT_W-1:0] cnt, mask;
  logic [COL_W-1:0] start;
  wrap_e            wrap;
  logic [CL_W-1:0]  cl;

  burst_ctrl #(.COL_W(COL_W), .CNT_W(CNT_W), .BL_W(2), .CL_W(CL_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_i, .stop_i, .col_i, .bl_sel_i, .wrap_ilv_i,
    .cl_sel_i(CL_W'(cl_sel_i)),
    .active_o(active), .cnt_o(cnt), .mask_o(mask), .start_o(start),
    .wrap_o(wrap), .cl_o(cl)
  );

  burst_addr_gen #(.COL_W(COL_W), .CNT_W(CNT_W)) u_addr (
    .clk_i, .rst_ni, .active_i(active), .cnt_i(cnt), .mask_i(mask),
    .start_i(start), .wrap_i(wrap), .col_o(col_o)
  );

  burst_lat_pipe #(.CL_W(CL_W)) u_lat (
    .clk_i, .rst_ni, .active_i(active), .cl_i(cl), .rd_vld_o(rd_vld_o)
  );

  assign busy_o = active;
endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_i = 1'b0;
  logic [8:0] col_i = '0;
  logic [1:0] bl_sel_i = '0;
  logic       wrap_ilv_i = 1'b0;
  logic [1:0] cl_sel_i = 2'd1;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       busy_o, rd_vld_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  burst_col_seq dut (.*);

  always #2.5 clk_i = ~clk_i;

  // reference model
  logic       m_act;
  int         m_cnt, m_len, m_cl;
  logic [8:0] m_start;
  logic       m_ilv;
  logic       hist [1:3];
  string      m_tag;

  function automatic logic [8:0] exp_col(logic [8:0] s, int len, logic ilv, int n);
    int lo;
    lo = ilv ? ((s % len) ^ n) : (((s % len) + n) % len);
    return 9'((s / len) * len + lo);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; m_cnt = 0; m_len = 1; m_cl = 1; m_start = '0; m_ilv = 0;
      hist[1] = 0; hist[2] = 0; hist[3] = 0; m_tag = "R8";
    end else begin
      cycles++;
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = m_act;
      if (cmd_i) begin
        m_tag = m_act ? "R5" : "R1";
        m_act = 1; m_cnt = 0; m_len = 1 << bl_sel_i; m_start = col_i;
        m_ilv = wrap_ilv_i; m_cl = (cl_sel_i == 0) ? 1 : int'(cl_sel_i);
      end else if (stop_i) begin
        if (m_act) m_tag = "R6";
        m_act = 0;
      end else if (m_act) begin
        m_tag = "R1";
        if (m_cnt == m_len - 1) m_act = 0;
        else m_cnt++;
      end
    end
  end

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic check_now();
    string ctag;
    chk(m_tag, 9'(busy_o), 9'(m_act));
    chk("R7", 9'(rd_vld_o), 9'(hist[m_cl]));
    if (m_act) begin
      ctag = (m_len == 1) ? "R4" : (m_ilv ? "R3" : "R2");
      chk(ctag, col_o, exp_col(m_start, m_len, m_ilv, m_cnt));
    end
  endtask

  task automatic cyc(logic c, logic [8:0] col, logic [1:0] bl, logic ilv, logic [1:0] cl, logic st);
    cmd_i = c; col_i = col; bl_sel_i = bl; wrap_ilv_i = ilv; cl_sel_i = cl; stop_i = st;
    @(negedge clk_i);
    check_now();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    chk("R8", 9'(busy_o), 9'd0);
    chk("R8", 9'(rd_vld_o), 9'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8", 9'(busy_o), 9'd0);
    // directed: every length and wrap order
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 4; b++) begin
        cyc(1'b1, 9'h1F5, 2'(b), 1'(w), 2'(b % 4), 1'b0);
        repeat (12) cyc(1'b0, '0, '0, 1'b0, '0, 1'b0);
      end
    end
    // directed: cut by command, cut by stop, command beats stop
    cyc(1'b1, 9'h0A3, 2'd3, 1'b0, 2'd3, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, '0, 1'b0);
    cyc(1'b1, 9'h136, 2'd2, 1'b1, 2'd2, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, '0, 1'b1);
    cyc(1'b1, 9'h047, 2'd3, 1'b1, 2'd0, 1'b1);
    repeat (10) cyc(1'b0, '0, '0, 1'b0, '0, 1'b0);
    // random
    for (int i = 0; i < 4000; i++) begin
      logic c, s;
      c = m_act ? ($urandom_range(0, 5) == 0) : ($urandom_range(0, 2) == 0);
      s = ($urandom_range(0, 19) == 0);
      cyc(c, 9'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), s);
    end
    repeat (8) cyc(1'b0, '0, '0, 1'b0, '0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule